// File: doc/BRIEF.md
# Trigger Output Select and Pulse Shaper

This block forms one output channel of a trigger crossbar. A binary source-select value picks one of `N_SRC` conditioned trigger inputs. The chosen signal then goes through a shaping stage. That stage can pass the signal through as a level, or turn it into a one-clock pulse on its rising edge, its falling edge or both edges. An invert control can then flip the shaped result. The shaped signal is registered and leaves the block as the internal trigger `trig_out`.

A separate pin-enable bit, taken from a global output-enable mask, decides whether the channel drives its IO pin `io_out`. When the bit is clear the pin is held at 0 while `trig_out` keeps running. All inputs are taken to be synchronous to `clk`.

Two independent enable bits choose the shaping: one for the rising edge and one for the falling edge. Setting both gives a pulse on either edge. Clearing both selects level pass-through.

Top module: `trig_out_channel`

## Requirements
- R1: While `rst_n` is low, `trig_out` and `io_out` are 0. The first clock edge after reset is released never produces an edge pulse, because no earlier sample exists to compare against.
- R2: `src_sel` is a binary index into `trig_in`, and bit i of `trig_in` is chosen when `src_sel` equals i. An index of `N_SRC` or higher selects a constant 0.
- R3: With `rise_en`=0 and `fall_en`=0 (level mode), `trig_out` one clock after an edge equals the selected input sampled at that edge, XOR `out_inv`.
- R4: With only `rise_en`=1, `trig_out` is (before inversion) high for exactly one clock after the edge at which the selected input is first seen 1 following a 0. Otherwise it is low.
- R5: With only `fall_en`=1, `trig_out` is (before inversion) high for exactly one clock after the edge at which the selected input is first seen 0 following a 1.
- R6: With `rise_en`=1 and `fall_en`=1, a one-clock pulse follows every change of the selected input.
- R7: Inversion is applied after shaping. With `out_inv`=1 in a pulse mode, `trig_out` idles at 1 and drops to 0 for one clock per detected edge.
- R8: If `src_sel` at a clock edge differs from its value at the previous edge, no edge pulse is produced from that edge. The edge history is reloaded from the newly selected input.
- R9: `io_out` equals `trig_out` while `io_en`=1 and is 0 while `io_en`=0. The gating is combinational and has no effect on `trig_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_SRC | Conditioned trigger inputs |
| src_sel | input | SEL_W | Binary index of the input feeding this channel |
| rise_en | input | 1 | Pulse on rising edge of the selected input |
| fall_en | input | 1 | Pulse on falling edge of the selected input |
| out_inv | input | 1 | Invert the shaped signal |
| io_en | input | 1 | This channel's bit of the global pin-enable mask |
| trig_out | output | 1 | Registered shaped trigger |
| io_out | output | 1 | Pin drive, gated by io_en |

## Verification
Several properties are checked on every clock. Single-edge pulses never last more than one clock. A change of source never yields a pulse. A falling-edge channel stays quiet while its input stays high. Level mode follows the selected input one clock later, and the pin output is 0 whenever the pin enable is low. Some behaviours are shown only by the bench's scenarios, which compare every clock against a behavioural model: the exact timing of each pulse under random input patterns, the inverted idle level, out-of-range source indices, and the suppressed first edge after reset.

// File: rtl/trig_pkg.sv
package trig_pkg;

    // Shaping mode: bit 1 is the rising-edge enable, bit 0 the falling-edge enable
    typedef enum logic [1:0] {
        SHAPE_LEVEL = 2'b00,
        SHAPE_FALL  = 2'b01,
        SHAPE_RISE  = 2'b10,
        SHAPE_BOTH  = 2'b11
    } shape_mode_e;

    typedef struct packed {
        logic hist;    // selected input one clock ago
        logic primed;  // a valid history sample exists
        logic out;     // registered shaped, inverted result
    } shaper_state_t;

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
    parameter int unsigned N_SRC = 6,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] trig_in,
    input  logic [SEL_W-1:0] src_sel,
    output logic             sel_val,
    output logic             switched
);

    logic [N_SRC-1:0] hit;
    logic [SEL_W-1:0] sel_d, sel_q;

    // AND-OR selection; an out-of-range index matches no lane
    for (genvar i = 0; i < N_SRC; i++) begin : g_lane
        assign hit[i] = trig_in[i] && (src_sel == SEL_W'(i));
    end

    assign sel_val  = |hit;
    assign switched = (src_sel != sel_q);

    always_comb begin
        sel_d = src_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

endmodule

// File: rtl/trig_edge_shaper.sv
module trig_edge_shaper
    import trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_val,
    input  logic switched,
    input  logic rise_en,
    input  logic fall_en,
    input  logic out_inv,
    output logic shaped_out
);

    shaper_state_t st_d, st_q;
    shape_mode_e   mode;
    logic          edge_ok, rise_hit, fall_hit, shaped;

    always_comb begin
        mode     = shape_mode_e'({rise_en, fall_en});
        edge_ok  = st_q.primed && !switched;
        rise_hit = edge_ok && sel_val && !st_q.hist;
        fall_hit = edge_ok && !sel_val && st_q.hist;
        unique case (mode)
            SHAPE_LEVEL: shaped = sel_val;
            SHAPE_FALL:  shaped = fall_hit;
            SHAPE_RISE:  shaped = rise_hit;
            SHAPE_BOTH:  shaped = rise_hit || fall_hit;
            default:     shaped = 1'b0;
        endcase
        st_d.hist   = sel_val;
        st_d.primed = 1'b1;
        st_d.out    = shaped ^ out_inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shaped_out = st_q.out;

    // R4: a rising-only, non-inverted pulse never lasts two clocks
    assert_single_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en && !fall_en && !out_inv && shaped_out)
        |=> !(rise_en && !fall_en && !out_inv && shaped_out));

    // R5: falling-only channel stays low while the input remains high
    assert_fall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en && fall_en && !out_inv && sel_val && st_q.hist) |=> !shaped_out);

    // R8: a source change never yields a pulse
    assert_no_switch_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_en || fall_en) && !out_inv && switched) |=> !shaped_out);

endmodule

// File: rtl/trig_out_channel.sv
module trig_out_channel #(
    parameter int unsigned N_SRC = 6,
    parameter int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] trig_in,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             out_inv,
    input  logic             io_en,
    output logic             trig_out,
    output logic             io_out
);

    logic sel_val, switched;

    trig_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .src_sel  (src_sel),
        .sel_val  (sel_val),
        .switched (switched)
    );

    trig_edge_shaper u_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_val    (sel_val),
        .switched   (switched),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .out_inv    (out_inv),
        .shaped_out (trig_out)
    );

    // Pin stage: drive forced low when the mask bit is clear
    assign io_out = trig_out & io_en;

    // R3: level mode follows the selected input one clock later
    assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en && !fall_en) |=> (trig_out == ($past(sel_val) ^ $past(out_inv))));

    // R9: no pin drive while the enable is low
    assert_pin_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |-> !io_out);

endmodule

// File: tb/tb_trig_out_channel.sv
module tb_trig_out_channel;

    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 6;
    localparam int SEL_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] trig_in = '0;
    logic [SEL_W-1:0] src_sel = '0;
    logic             rise_en = 1'b0, fall_en = 1'b0, out_inv = 1'b0, io_en = 1'b0;
    logic             trig_out, io_out;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    trig_out_channel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src_sel(src_sel),
        .rise_en(rise_en), .fall_en(fall_en), .out_inv(out_inv), .io_en(io_en),
        .trig_out(trig_out), .io_out(io_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: expected trig_out after each edge
    int m_hist = 0, m_prev_sel = 0, m_primed = 0, m_exp = 0;
    always @(posedge clk) begin
        int s, r, f, chg, sh;
        if (!rst_n) begin
            m_hist = 0; m_prev_sel = 0; m_primed = 0; m_exp = 0;
        end else begin
            s   = (int'(src_sel) < N_SRC) ? int'(trig_in[src_sel]) : 0;
            chg = (int'(src_sel) != m_prev_sel);
            r   = (m_primed && !chg && s == 1 && m_hist == 0) ? 1 : 0;
            f   = (m_primed && !chg && s == 0 && m_hist == 1) ? 1 : 0;
            if (!rise_en && !fall_en) sh = s;
            else sh = (rise_en ? r : 0) | (fall_en ? f : 0);
            m_exp = sh ^ int'(out_inv);
            m_hist = s; m_prev_sel = int'(src_sel); m_primed = 1;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: compare after the edge, then caller drives new inputs
    task automatic tick();
        @(posedge clk);
        #1;
        check(cur_req, int'(trig_out), m_exp, "trig_out");
        check(cur_req, int'(io_out), io_en ? m_exp : 0, "io_out");
    endtask

    task automatic run_random(int n, int sel_change_pct);
        for (int k = 0; k < n; k++) begin
            tick();
            trig_in = N_SRC'($urandom);
            if (int'($urandom_range(99)) < sel_change_pct) src_sel = SEL_W'($urandom_range(N_SRC - 1));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low
        trig_in = '1; io_en = 1'b1; out_inv = 1'b0; src_sel = 3'd2;
        for (int k = 0; k < 3; k++) tick();
        check("R1", int'(trig_out), 0, "trig_out in reset");
        // R1: input already high at release, rise mode: no pulse on first edge
        rise_en = 1'b1;
        rst_n = 1'b1;
        tick();
        check("R1", int'(trig_out), 0, "first edge after reset");
        tick();

        // R4: directed rising pulse, one clock wide
        cur_req = "R4";
        trig_in[2] = 1'b0; tick();
        trig_in[2] = 1'b1; tick();
        check("R4", int'(trig_out), 1, "rise pulse");
        tick();
        check("R4", int'(trig_out), 0, "rise pulse ends");
        run_random(300, 0);

        // R5: falling edge only
        cur_req = "R5"; rise_en = 1'b0; fall_en = 1'b1;
        trig_in[2] = 1'b1; tick(); tick();
        trig_in[2] = 1'b0; tick();
        check("R5", int'(trig_out), 1, "fall pulse");
        run_random(300, 0);

        // R6: both edges
        cur_req = "R6"; rise_en = 1'b1;
        run_random(300, 0);

        // R7: inverted pulses idle high
        cur_req = "R7"; out_inv = 1'b1;
        trig_in = '0; tick(); tick();
        check("R7", int'(trig_out), 1, "inverted idle");
        trig_in[2] = 1'b1; tick();
        check("R7", int'(trig_out), 0, "inverted pulse dips");
        run_random(300, 0);
        fall_en = 1'b0;
        run_random(200, 0);

        // R3: level mode, plain and inverted
        cur_req = "R3"; rise_en = 1'b0; fall_en = 1'b0; out_inv = 1'b0;
        run_random(300, 0);
        out_inv = 1'b1;
        run_random(200, 0);

        // R8: switching sources while in pulse modes
        cur_req = "R8"; out_inv = 1'b0; rise_en = 1'b1;
        trig_in = 6'b000001; src_sel = 3'd0; tick(); tick();
        src_sel = 3'd1; tick();
        src_sel = 3'd0; tick();
        check("R8", int'(trig_out), 0, "switch to high source");
        fall_en = 1'b1;
        run_random(600, 40);

        // R2: every index, including out-of-range ones
        cur_req = "R2"; rise_en = 1'b0; fall_en = 1'b0; out_inv = 1'b0;
        for (int i = 0; i < (1 << SEL_W); i++) begin
            src_sel = SEL_W'(i);
            trig_in = N_SRC'(1) << (i % N_SRC);
            tick(); tick();
            check("R2", int'(trig_out), (i < N_SRC) ? 1 : 0, "lane select");
        end
        run_random(300, 30);

        // R9: pin gating does not touch trig_out
        cur_req = "R9";
        src_sel = 3'd3; trig_in = '1; io_en = 1'b0; tick(); tick();
        check("R9", int'(io_out), 0, "pin held low");
        check("R9", int'(trig_out), 1, "internal trigger alive");
        for (int k = 0; k < 300; k++) begin
            io_en = k[2];
            tick();
            trig_in = N_SRC'($urandom);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule